// File: doc/BRIEF.md
# Vector Branch Condition Reduction Sequencer

This block turns a vector of 4-bit condition fields into one branch-taken decision. After a start pulse it steps through the elements in order, one per clock. For each element it reads a field through a read port, tests one selected bit, and checks the count register. It then merges that element's result into a running AND (all-of mode) or a running OR (any-of mode). The walk stops early at the first element that settles the result, so no condition field past the deciding one is ever read.

The block also applies the side effects a vector branch carries. It decrements the count register under a choice of rules, including rules that depend on the test outcome. It can cut the vector length at the exit element. Elements that the predicate masks out are either skipped or tested against a forced bit value. A scalar source stops the walk after the first element. The final condition, count, length and a one-cycle done strobe are presented together.

Top module: `vbr_reduce_seq`

## Requirements
- R1: After reset, done_o, cf_rd_o and cond_o are 0.
- R2: For a tested element, the test bit is cf_data_i[bi_i]. The element condition is bo_i[0] OR NOT(test bit XOR bo_i[1]).
- R3: The count condition is bo_i[2] OR (count nonzero XOR bo_i[3]). It is taken on the count value before that element's decrement. An element passes only if both the element condition and the count condition hold.
- R4: With all_i=1 the running result starts at 1, is ANDed with each pass bit, and the walk stops at the first failing element. With all_i=0 it starts at 0, is ORed, and the walk stops at the first passing element. Otherwise the walk ends after element vl_i-1.
- R5: For a tested element with bo_i[2]=0, the count decrements by one, unless ctr_test_i=1 and (element condition XOR cti_i)=1. With bo_i[2]=1 the count never changes.
- R6: An element whose pred_i bit is 0 with sz_i=0 is skipped. It issues no read and leaves the running result unchanged. The count decrements only if bo_i[2]=0, ctr_test_i=1 and cti_i=0.
- R7: An element whose pred_i bit is 0 with sz_i=1 issues no read, and its test bit is snz_i.
- R8: With vlset_i=1, when a tested element's pass bit equals vsb_i, the walk stops and vl_o becomes step+1 if vli_i=1, else step.
- R9: With scalar_i=1 the walk ends after element 0.
- R10: With vl_i=0, done_o rises after the start edge with no read. cond_o equals the start value of R4 and the count is unchanged.
- R11: With mode32_i=1 the nonzero test of R3 looks only at the low 32 bits of the count.
- R12: Element s is read in the s-th cycle after the start edge at index base_i+s (modulo the index range). Every instruction restarts from step 0. done_o is high for exactly one cycle, n edges after the start edge, where n is the number of elements visited.
- R13: When no truncation occurs, vl_o equals vl_i. Starts while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, samples all set-up inputs |
| bo_i | input | 4 | [0] ignore cond, [1] wanted bit, [2] ignore count, [3] zero sense |
| bi_i | input | 2 | Bit select within a condition field |
| all_i | input | 1 | 1: all-of reduction, 0: any-of |
| sz_i | input | 1 | Masked elements tested against snz_i instead of skipped |
| snz_i | input | 1 | Forced test bit for masked elements |
| ctr_test_i | input | 1 | Make count decrement depend on the test |
| cti_i | input | 1 | Inverts the count-test sense |
| vlset_i | input | 1 | Enable length truncation |
| vsb_i | input | 1 | Pass value that triggers truncation |
| vli_i | input | 1 | Truncated length includes the exit element |
| scalar_i | input | 1 | Source field is scalar |
| mode32_i | input | 1 | Count nonzero test on low 32 bits |
| base_i | input | IDX_W | Index of the first condition field |
| pred_i | input | MAX_VL | Predicate mask, bit s for element s |
| vl_i | input | VL_W | Vector length |
| ctr_i | input | CTR_W | Count register at start |
| cf_rd_o | output | 1 | Condition-field read strobe |
| cf_idx_o | output | IDX_W | Condition-field read index |
| cf_data_i | input | 4 | Field data, same cycle as the index |
| done_o | output | 1 | One-cycle completion strobe |
| cond_o | output | 1 | Reduced branch condition |
| ctr_o | output | CTR_W | Updated count register |
| vl_o | output | VL_W | Resulting vector length |

## Verification
Each result is due a fixed number of edges after the start edge: the n-th visited element settles on edge start+n, and done_o, cond_o, ctr_o and vl_o are sampled on the falling edge that follows. A length of zero gives n=0. The driver computes n together with the expected condition, count, length and read count, and stamps the start cycle. The monitor compares the observed latency against n and checks each read index against base plus the cycles elapsed. Every sample is taken on a falling edge, so all values are settled.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  typedef struct packed {
    logic [3:0] bo;
    logic [1:0] bi;
    logic       all;
    logic       sz;
    logic       snz;
    logic       ctr_test;
    logic       cti;
    logic       vlset;
    logic       vsb;
    logic       vli;
    logic       scalar;
    logic       mode32;
  } cfg_t;
endpackage

// File: rtl/vbr_elem_eval.sv
module vbr_elem_eval
  import vbr_pkg::*;
(
  input  cfg_t       cfg_i,
  input  logic       masked_i,
  input  logic [3:0] cf_bits_i,
  input  logic       ctr_nz_i,
  output logic       skip_o,
  output logic       pass_o,
  output logic       dec_o
);
  logic test_bit, el_ok, ctr_ok;

  always_comb begin
    test_bit = masked_i ? cfg_i.snz : cf_bits_i[cfg_i.bi];
    el_ok    = cfg_i.bo[0] | ~(test_bit ^ cfg_i.bo[1]);
    ctr_ok   = cfg_i.bo[2] | (ctr_nz_i ^ cfg_i.bo[3]);
    pass_o   = el_ok & ctr_ok;
    skip_o   = masked_i & ~cfg_i.sz;
    if (skip_o) dec_o = ~cfg_i.bo[2] & cfg_i.ctr_test & ~cfg_i.cti;
    else        dec_o = ~cfg_i.bo[2] & ~(cfg_i.ctr_test & (el_ok ^ cfg_i.cti));
  end
endmodule

// File: rtl/vbr_ctr_unit.sv
module vbr_ctr_unit #(
  parameter int CTR_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CTR_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             mode32_i,
  output logic [CTR_W-1:0] count_o,
  output logic             nz_o
);
  logic [CTR_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (dec_i)  count_q <= count_q - CTR_W'(1);
  end

  generate
    if (CTR_W > 32) begin : g_wide
      assign nz_o = mode32_i ? (|count_q[31:0]) : (|count_q);
    end else begin : g_narrow
      logic unused_mode;
      assign unused_mode = mode32_i;
      assign nz_o = |count_q;
    end
  endgenerate

  assign count_o = count_q;
endmodule

// File: rtl/vbr_step_ctrl.sv
module vbr_step_ctrl
  import vbr_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            exit_i,
  output logic            busy_o,
  output logic [VL_W-1:0] step_o,
  output logic            last_o
);
  st_e             st_q;
  logic [VL_W-1:0] step_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      lim_q  <= '0;
    end else if (st_q == ST_IDLE) begin
      if (start_i && vl_i != '0) begin
        st_q   <= ST_RUN;
        step_q <= '0;
        lim_q  <= vl_i;
      end
    end else if (exit_i) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      step_q <= step_q + VL_W'(1);
    end
  end

  assign busy_o = (st_q == ST_RUN);
  assign step_o = step_q;
  assign last_o = (step_q + VL_W'(1)) == lim_q;
endmodule

// File: rtl/vbr_reduce_seq.sv
module vbr_reduce_seq
  import vbr_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 7,
  parameter int CTR_W  = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        bo_i,
  input  logic [1:0]        bi_i,
  input  logic              all_i,
  input  logic              sz_i,
  input  logic              snz_i,
  input  logic              ctr_test_i,
  input  logic              cti_i,
  input  logic              vlset_i,
  input  logic              vsb_i,
  input  logic              vli_i,
  input  logic              scalar_i,
  input  logic              mode32_i,
  input  logic [IDX_W-1:0]  base_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [CTR_W-1:0]  ctr_i,
  output logic              cf_rd_o,
  output logic [IDX_W-1:0]  cf_idx_o,
  input  logic [3:0]        cf_data_i,
  output logic              done_o,
  output logic              cond_o,
  output logic [CTR_W-1:0]  ctr_o,
  output logic [VL_W-1:0]   vl_o
);
  localparam int SEL_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

  cfg_t              cfg_q;
  logic [MAX_VL-1:0] pred_q;
  logic [IDX_W-1:0]  base_q;
  logic [VL_W-1:0]   vl_eff, vl_out_q, step;
  logic              acc_q, done_q, busy, last, start_ok;
  logic              masked, skip, pass, dec, ctr_nz, vset_hit, exit_w;

  assign start_ok = start_i & ~busy;
  assign vl_eff   = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;

  vbr_step_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_ok),
    .vl_i   (vl_eff),
    .exit_i (exit_w),
    .busy_o (busy),
    .step_o (step),
    .last_o (last)
  );

  assign masked = ~pred_q[step[SEL_W-1:0]];

  vbr_elem_eval u_eval (
    .cfg_i    (cfg_q),
    .masked_i (masked),
    .cf_bits_i(cf_data_i),
    .ctr_nz_i (ctr_nz),
    .skip_o   (skip),
    .pass_o   (pass),
    .dec_o    (dec)
  );

  vbr_ctr_unit #(.CTR_W(CTR_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_ok),
    .load_val_i(ctr_i),
    .dec_i     (busy & dec),
    .mode32_i  (cfg_q.mode32),
    .count_o   (ctr_o),
    .nz_o      (ctr_nz)
  );

  assign vset_hit = cfg_q.vlset & (pass == cfg_q.vsb);
  // skipped elements never trigger the test-based exits
  assign exit_w = busy & (last | cfg_q.scalar |
                  (~skip & (vset_hit | (cfg_q.all != pass))));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      pred_q   <= '0;
      base_q   <= '0;
      acc_q    <= 1'b0;
      vl_out_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        cfg_q    <= '{bo: bo_i, bi: bi_i, all: all_i, sz: sz_i, snz: snz_i,
                      ctr_test: ctr_test_i, cti: cti_i, vlset: vlset_i,
                      vsb: vsb_i, vli: vli_i, scalar: scalar_i, mode32: mode32_i};
        pred_q   <= pred_i;
        base_q   <= base_i;
        acc_q    <= all_i;
        vl_out_q <= vl_i;
        done_q   <= (vl_i == '0);
      end else if (busy) begin
        if (!skip) acc_q <= cfg_q.all ? (acc_q & pass) : (acc_q | pass);
        if (!skip && vset_hit)
          vl_out_q <= cfg_q.vli ? step + VL_W'(1) : step;
        done_q <= exit_w;
      end
    end
  end

  assign cf_rd_o  = busy & ~masked;
  assign cf_idx_o = base_q + IDX_W'(step);
  assign done_o   = done_q;
  assign cond_o   = acc_q;
  assign vl_o     = vl_out_q;
endmodule

// File: rtl/vbr_seq_chk.sv
module vbr_seq_chk #(
  parameter int IDX_W = 7,
  parameter int CTR_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             ign_ctr_i,
  input logic             done_i,
  input logic             rd_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [CTR_W-1:0] ctr_i
);
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  p_idle_no_rd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !rd_i);

  p_idx_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> idx_i == IDX_W'($past(idx_i) + 1'b1));

  p_ctr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (ctr_i == $past(ctr_i) || ctr_i == CTR_W'($past(ctr_i) - 1'b1)));

  p_ctr_ign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ign_ctr_i) |=> $stable(ctr_i));

  p_ctr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(ctr_i));
endmodule

bind vbr_reduce_seq vbr_seq_chk #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_i   (busy),
  .ign_ctr_i(cfg_q.bo[2]),
  .done_i   (done_o),
  .rd_i     (cf_rd_o),
  .idx_i    (cf_idx_o),
  .ctr_i    (ctr_o)
);

// File: tb/vbr_reduce_seq_tb.sv
module vbr_reduce_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0]  bo;
  logic [1:0]  bi;
  logic        all_m, sz, snz, ctest, cti, vlset, vsb, vli, scalar, m32;
  logic [6:0]  base;
  logic [63:0] pred;
  logic [6:0]  vl;
  logic [63:0] ctr;
  logic        cf_rd, done, cond;
  logic [6:0]  cf_idx, vl_out;
  logic [3:0]  cf_data;
  logic [63:0] ctr_out;
  logic [3:0]  cf_mem [128];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cf_data = cf_mem[cf_idx];

  vbr_reduce_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bo_i(bo), .bi_i(bi),
    .all_i(all_m), .sz_i(sz), .snz_i(snz), .ctr_test_i(ctest), .cti_i(cti),
    .vlset_i(vlset), .vsb_i(vsb), .vli_i(vli), .scalar_i(scalar),
    .mode32_i(m32), .base_i(base), .pred_i(pred), .vl_i(vl), .ctr_i(ctr),
    .cf_rd_o(cf_rd), .cf_idx_o(cf_idx), .cf_data_i(cf_data), .done_o(done),
    .cond_o(cond), .ctr_o(ctr_out), .vl_o(vl_out)
  );

  typedef struct {
    logic        cond;
    logic [63:0] ctr;
    logic [6:0]  vl;
    int          lat;
    int          reads;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   cyc = 0, start_cyc = 0, rd_cnt = 0, idx_err = 0;
  int   checks = 0, errors = 0;
  logic [6:0] cur_base;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (cf_rd) begin
      rd_cnt++;
      if (cf_idx != 7'(cur_base + 7'(cyc - start_cyc))) idx_err++;
    end
    if (done) begin
      if (sb_q.size() == 0) chk("R12 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " cond"}, 64'(cond), 64'(e.cond));
        chk({e.tag, " count (R5)"}, ctr_out, e.ctr);
        chk({e.tag, " length (R13/R8)"}, 64'(vl_out), 64'(e.vl));
        chk({e.tag, " latency (R12)"}, 64'(cyc - start_cyc), 64'(e.lat));
        chk({e.tag, " reads (R12)"}, 64'(rd_cnt), 64'(e.reads));
        chk({e.tag, " read index (R12)"}, 64'(idx_err), 64'd0);
      end
    end
  end

  task automatic defaults();
    bo = 4'b0110; bi = 2'd0; all_m = 0; sz = 0; snz = 0; ctest = 0; cti = 0;
    vlset = 0; vsb = 0; vli = 0; scalar = 0; m32 = 0; base = 7'd8;
    pred = '1; vl = 7'd4; ctr = 64'd10;
    for (int i = 0; i < 128; i++) cf_mem[i] = 4'h0;
  endtask

  // driver: model from the requirements, push, start, wait
  task automatic go(string tag);
    exp_t e;
    logic [63:0] c;
    logic acc, masked, tb, el, cok, p, nz;
    c = ctr; acc = all_m; e.vl = vl; e.lat = 0; e.reads = 0;
    for (int s = 0; s < int'(vl); s++) begin
      e.lat++;
      masked = ~pred[s];
      nz = m32 ? (c[31:0] != 0) : (c != 0);
      if (masked && !sz) begin
        if (!bo[2] && ctest && !cti) c = c - 1;
        if (scalar) break;
        continue;
      end
      if (masked) tb = snz;
      else begin
        tb = cf_mem[7'(base + 7'(s))][bi];
        e.reads++;
      end
      el  = bo[0] | ~(tb ^ bo[1]);
      cok = bo[2] | (nz ^ bo[3]);
      p   = el & cok;
      if (!bo[2] && !(ctest && (el ^ cti))) c = c - 1;
      acc = all_m ? (acc & p) : (acc | p);
      if (vlset && p == vsb) begin
        e.vl = vli ? 7'(s + 1) : 7'(s);
        break;
      end
      if (all_m != p) break;
      if (scalar) break;
    end
    e.cond = acc; e.ctr = c; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    rd_cnt = 0; idx_err = 0; cur_base = base; start_cyc = cyc + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    chk("R1 done after reset", 64'(done), 0);
    chk("R1 read after reset", 64'(cf_rd), 0);
    chk("R1 cond after reset", 64'(cond), 0);
    rst_n = 1'b1;
    @(negedge clk);

    defaults(); cf_mem[10] = 4'h1; go("R4 R2 any-of exit at first pass");
    defaults(); all_m = 1; for (int i = 8; i < 12; i++) cf_mem[i] = 4'h1;
    go("R4 all-of full walk");
    defaults(); all_m = 1; cf_mem[8] = 4'h1; go("R4 all-of exit at first fail");
    defaults(); bi = 2'd2; bo = 4'b0100; cf_mem[8] = 4'h4; cf_mem[9] = 4'hB;
    go("R2 bit select and zero sense");
    defaults(); all_m = 1; bo = 4'b0001; ctr = 64'd2; vl = 7'd5;
    go("R3 R5 count gates passes");
    defaults(); bo = 4'b1001; ctr = 64'd0; vl = 7'd3; go("R3 zero sense with zero count");
    defaults(); bo = 4'b0010; ctest = 1; cti = 0; all_m = 1;
    cf_mem[8] = 4'h1; cf_mem[9] = 4'h1; go("R5 count test suppresses on pass");
    defaults(); bo = 4'b0010; ctest = 1; cti = 1; all_m = 1;
    cf_mem[8] = 4'h1; cf_mem[9] = 4'h1; go("R5 count test inverted");
    defaults(); bo = 4'b0010; ctest = 1; pred = 64'hA; vl = 7'd4; cf_mem[11] = 4'h1;
    go("R6 masked skip with decrement");
    defaults(); pred = 64'h0; vl = 7'd3; go("R6 all masked any-of");
    defaults(); all_m = 1; sz = 1; snz = 1; pred = 64'h5;
    cf_mem[8] = 4'h1; cf_mem[10] = 4'h1; go("R7 forced one for masked");
    defaults(); all_m = 1; sz = 1; snz = 0; pred = 64'h1; cf_mem[8] = 4'h1;
    go("R7 forced zero for masked");
    defaults(); vlset = 1; vsb = 1; vli = 0; vl = 7'd6; cf_mem[11] = 4'h1;
    go("R8 truncate exclusive");
    defaults(); vlset = 1; vsb = 1; vli = 1; vl = 7'd6; cf_mem[11] = 4'h1;
    go("R8 truncate inclusive");
    defaults(); all_m = 1; scalar = 1; for (int i = 8; i < 12; i++) cf_mem[i] = 4'h1;
    go("R9 scalar single element");
    defaults(); all_m = 1; vl = 7'd0; go("R10 zero length all-of");
    defaults(); vl = 7'd0; bo = 4'b0000; go("R10 zero length any-of");
    defaults(); all_m = 1; bo = 4'b0101; m32 = 1; ctr = 64'h1_0000_0000;
    go("R11 low half zero in 32-bit mode");
    defaults(); all_m = 1; bo = 4'b0101; m32 = 0; ctr = 64'h1_0000_0000;
    go("R11 full width nonzero");
    defaults(); all_m = 1; base = 7'd100; vl = 7'd64;
    for (int i = 0; i < 128; i++) cf_mem[i] = 4'h1;
    go("R4 R12 full length with index wrap");

    // R13: start while busy is ignored
    defaults(); all_m = 1; vl = 7'd4; for (int i = 8; i < 12; i++) cf_mem[i] = 4'h1;
    fork
      go("R13 overlapping start ignored");
      begin
        repeat (3) @(negedge clk);
        vl = 7'd1; ctr = 64'd99;
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    join

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule